// File: doc/BRIEF.md
# Page Access Rights Checker

This block sits behind a page-table walker. It receives the final entry the walker found, together with the kind of access (load, store or instruction fetch), the privilege level of the requester and the virtual address. It decides whether the access may proceed and which read, write and execute rights may be cached for the page. A walk that has already failed is passed through as a translation fault with its level.

When an access is rejected, the block records the event in a fault status register and the virtual address in a fault address register. It then raises a one-cycle trap request, tagged as an instruction or a data fault. Software clears the status register by reading it. A status register that is still non-zero when the next fault arrives is marked as overflowed. A no-fault mode control suppresses traps. In that mode every rejected access is granted full rights, and the fault is still recorded.

Top module: `acc_chk`

## Requirements
- R1: The access index is {store, fetch, supervisor}, with bit 2 set for a store, bit 1 set for a fetch and bit 0 set for a supervisor access. `acc_kind` encodes 0 as load, 1 as store and 2 as fetch; 3 is treated as a load.
- R2: The permission code sits in entry bits [4:2]. A user access to code 6 or 7 is a privilege fault (fault type 3). Any other access whose needed right (read for a load, write for a store, execute for a fetch) is missing from the code's rights is a protection fault (fault type 2).
- R3: The rights {r,w,x} for each code are: 0 R, 1 RW, 2 RX, 3 RWX, 4 X. For code 5 they are R for user and RW for supervisor. For code 6 they are none for user and RX for supervisor. For code 7 they are none for user and RWX for supervisor.
- R4: Write rights are granted only when the modified bit, entry bit 6, is set.
- R5: A non-zero `walk_ft` is a translation fault. It is reported with that fault type and with `walk_lvl`. A permission fault reports level 0.
- R6: On a fault, the status register loads (level<<8) | (index<<5) | (type<<2) | 2, and the fault address register loads `vaddr`.
- R7: If the status register is non-zero when a new fault is loaded, bit 0 is set to mark overflow.
- R8: A cycle with `fsr_rd` high clears the status register on the next cycle. A fault in the same cycle is loaded without overflow.
- R9: A fault outside no-fault mode raises `trap` for exactly the result cycle, with `trap_fetch` set when the access was a fetch. The rights output is then all zero.
- R10: In no-fault mode, a faulting access raises no trap and is granted rights RWX. Its status and address are still recorded.
- R11: All results appear on the cycle after `chk_valid`, qualified by a one-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A check request is present this cycle |
| chk_entry | input | 32 | Final entry from the walk |
| walk_ft | input | 3 | Walk fault type, 0 when the walk succeeded |
| walk_lvl | input | 2 | Table level at which the walk failed |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| is_super | input | 1 | Requester is in supervisor mode |
| vaddr | input | 32 | Virtual address of the access |
| nofault_mode | input | 1 | Suppress traps and grant full rights on a fault |
| fsr_rd | input | 1 | Status register read strobe (clears it) |
| done | output | 1 | Result valid pulse |
| perm_r | output | 1 | Read right granted |
| perm_w | output | 1 | Write right granted |
| perm_x | output | 1 | Execute right granted |
| trap | output | 1 | Fault trap request pulse |
| trap_fetch | output | 1 | Trap is for an instruction fetch |
| fsr | output | 10 | Fault status register |
| far | output | 32 | Fault address register |

## Verification
Every result of a request is due one cycle after the request: rights, `done`, `trap`, `trap_fetch`, and the new status and address values. The driver applies a request on a falling edge and queues the expected item. A monitor pops that item on the next falling edge where `done` is high, so the clock edge that loads the results lies between the two. The clearing effect of a status read shows one cycle after the strobe. The bench samples `fsr` on the falling edge after the strobe and updates its own status model at the same point.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;
  localparam int ENT_W       = 32;
  localparam int VA_W        = 32;
  localparam int ENT_ACC_LO  = 2;
  localparam int ENT_MOD_BIT = 6;
  localparam int FSR_OVF     = 0;
  localparam int FSR_FAV     = 1;
  localparam int FSR_FT_LO   = 2;
  localparam int FSR_IDX_LO  = 5;
  localparam int FSR_LVL_LO  = 8;
  localparam int FSR_W       = FSR_LVL_LO + 2;

  localparam logic [2:0] FT_NONE = 3'd0;
  localparam logic [2:0] FT_PROT = 3'd2;
  localparam logic [2:0] FT_PRIV = 3'd3;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/acc_lookup.sv
module acc_lookup
  import acc_chk_pkg::*;
(
  input  logic [2:0] acc_idx,
  input  logic [2:0] perm_code,
  output logic [2:0] fault_ft,
  output logic [2:0] rights
);
  localparam logic [1:0] OK = 2'b00;
  localparam logic [1:0] PF = 2'b10;
  localparam logic [1:0] VF = 2'b11;

  logic [15:0] row;
  logic [1:0]  ent;
  logic        user;

  assign user = ~acc_idx[0];

  // Rows are written with code 7 on the left, code 0 on the right.
  always_comb begin
    unique case (acc_idx)
      3'd0: row = {VF, VF, OK, PF, OK, OK, OK, OK};
      3'd1: row = {OK, OK, OK, PF, OK, OK, OK, OK};
      3'd2: row = {VF, VF, PF, OK, OK, OK, PF, PF};
      3'd3: row = {OK, OK, PF, OK, OK, OK, PF, PF};
      3'd4: row = {VF, VF, PF, PF, OK, PF, OK, PF};
      3'd5: row = {OK, PF, OK, PF, OK, PF, OK, PF};
      3'd6: row = {VF, VF, PF, PF, OK, PF, PF, PF};
      default: row = {OK, PF, PF, PF, OK, PF, PF, PF};
    endcase
  end

  assign ent      = row[{perm_code, 1'b0} +: 2];
  assign fault_ft = {1'b0, ent};

  always_comb begin
    unique case (perm_code)
      3'd0: rights = 3'b100;
      3'd1: rights = 3'b110;
      3'd2: rights = 3'b101;
      3'd3: rights = 3'b111;
      3'd4: rights = 3'b001;
      3'd5: rights = user ? 3'b100 : 3'b110;
      3'd6: rights = user ? 3'b000 : 3'b101;
      default: rights = user ? 3'b000 : 3'b111;
    endcase
  end
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import acc_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rd,
  input  logic [2:0]       idx,
  input  logic [1:0]       lvl,
  input  logic [2:0]       ft,
  input  logic [VA_W-1:0]  va,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q
);
  logic [FSR_W-1:0] base, fsr_n, rec;
  logic [VA_W-1:0]  far_n;
  logic             fsr_en;

  always_comb begin
    base = rd ? '0 : fsr_q;
    rec  = '0;
    rec[FSR_OVF]                  = (base != '0);
    rec[FSR_FAV]                  = 1'b1;
    rec[FSR_FT_LO  +: 3]          = ft;
    rec[FSR_IDX_LO +: 3]          = idx;
    rec[FSR_LVL_LO +: 2]          = lvl;
    fsr_n  = load ? rec : base;
    fsr_en = load | rd;
    far_n  = va;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      if (fsr_en) fsr_q <= fsr_n;
      if (load)   far_q <= far_n;
    end
  end
endmodule

// File: rtl/acc_chk.sv
module acc_chk
  import acc_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_valid,
  input  logic [ENT_W-1:0] chk_entry,
  input  logic [2:0]       walk_ft,
  input  logic [1:0]       walk_lvl,
  input  logic [1:0]       acc_kind,
  input  logic             is_super,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             nofault_mode,
  input  logic             fsr_rd,
  output logic             done,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic             trap,
  output logic             trap_fetch,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far
);
  logic [2:0] acc_idx, perm_code, tab_ft, tab_rights, f_ft, rights_n;
  logic [1:0] f_lvl;
  logic       is_store, is_fetch, walk_bad, faulted, trap_n;
  logic       done_q, trap_q, tfetch_q;
  logic [2:0] rights_q;

  assign is_store  = (acc_kind == KIND_STORE);
  assign is_fetch  = (acc_kind == KIND_FETCH);
  assign acc_idx   = {is_store, is_fetch, is_super};
  assign perm_code = chk_entry[ENT_ACC_LO +: 3];

  acc_lookup u_lookup (
    .acc_idx   (acc_idx),
    .perm_code (perm_code),
    .fault_ft  (tab_ft),
    .rights    (tab_rights)
  );

  always_comb begin
    walk_bad = (walk_ft != FT_NONE);
    f_ft     = walk_bad ? walk_ft : tab_ft;
    f_lvl    = walk_bad ? walk_lvl : 2'd0;
    faulted  = chk_valid & (f_ft != FT_NONE);
    trap_n   = faulted & ~nofault_mode;
    if (f_ft != FT_NONE)
      rights_n = nofault_mode ? 3'b111 : 3'b000;
    else
      rights_n = {tab_rights[2], tab_rights[1] & chk_entry[ENT_MOD_BIT], tab_rights[0]};
  end

  fault_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (faulted),
    .rd    (fsr_rd),
    .idx   (acc_idx),
    .lvl   (f_lvl),
    .ft    (f_ft),
    .va    (vaddr),
    .fsr_q (fsr),
    .far_q (far)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      trap_q   <= 1'b0;
      tfetch_q <= 1'b0;
      rights_q <= '0;
    end else begin
      done_q   <= chk_valid;
      trap_q   <= trap_n;
      tfetch_q <= trap_n & is_fetch;
      if (chk_valid) rights_q <= rights_n;
    end
  end

  assign done       = done_q;
  assign trap       = trap_q;
  assign trap_fetch = tfetch_q;
  assign perm_r     = rights_q[2];
  assign perm_w     = rights_q[1];
  assign perm_x     = rights_q[0];
endmodule

// File: rtl/acc_chk_sva.sv
module acc_chk_sva
  import acc_chk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             chk_valid,
  input logic [ENT_W-1:0] chk_entry,
  input logic             nofault_mode,
  input logic             fsr_rd,
  input logic [VA_W-1:0]  vaddr,
  input logic             done,
  input logic             perm_r,
  input logic             perm_w,
  input logic             perm_x,
  input logic             trap,
  input logic             trap_fetch,
  input logic [FSR_W-1:0] fsr,
  input logic [VA_W-1:0]  far
);
  assert_result_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> done);

  assert_trap_with_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done && !perm_r && !perm_w && !perm_x);

  assert_tag_needs_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fetch |-> trap);

  assert_no_trap_nofault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && nofault_mode |=> !trap);

  assert_write_needs_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_entry[ENT_MOD_BIT] && !trap_fetch |=> !perm_w || !trap && perm_r && perm_x);

  assert_trap_records_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> !trap || (fsr[FSR_FAV] && far == $past(vaddr)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_rd && !chk_valid |=> fsr == '0);
endmodule

bind acc_chk acc_chk_sva u_sva (.*);

// File: tb/sim_acc_chk.sv
module sim_acc_chk;
  logic        clk, rst_n;
  logic        chk_valid, is_super, nofault_mode, fsr_rd;
  logic [31:0] chk_entry, vaddr, far;
  logic [2:0]  walk_ft;
  logic [1:0]  walk_lvl, acc_kind;
  logic        done, perm_r, perm_w, perm_x, trap, trap_fetch;
  logic [9:0]  fsr;

  typedef struct packed {
    logic [2:0]  rights;
    logic        trap;
    logic        tfetch;
    logic [9:0]  fsr;
    logic [31:0] far;
  } item_t;

  item_t  exp_q[$];
  string  tag_q[$];
  int     checks = 0, errors = 0;
  logic [9:0]  m_fsr;
  logic [31:0] m_far;

  acc_chk u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2:0] model_rights(input logic user, input logic [2:0] c);
    case (c)
      3'd0: return 3'b100;
      3'd1: return 3'b110;
      3'd2: return 3'b101;
      3'd3: return 3'b111;
      3'd4: return 3'b001;
      3'd5: return user ? 3'b100 : 3'b110;
      3'd6: return user ? 3'b000 : 3'b101;
      default: return user ? 3'b000 : 3'b111;
    endcase
  endfunction

  function automatic logic [2:0] model_ft(input logic [1:0] k, input logic user, input logic [2:0] c);
    logic [2:0] rt;
    logic need;
    rt = model_rights(user, c);
    if (user && c >= 3'd6) return 3'd3;
    need = (k == 2'd1) ? rt[1] : (k == 2'd2) ? rt[0] : rt[2];
    return need ? 3'd0 : 3'd2;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic req(input string t, input logic [1:0] k, input logic sup, input logic [2:0] code,
                     input logic md, input logic [2:0] wft, input logic [1:0] lvl,
                     input logic [31:0] va, input logic nf);
    item_t e;
    logic [2:0] ft, idx;
    logic [1:0] fl;
    @(negedge clk);
    chk_valid = 1'b1; acc_kind = k; is_super = sup; walk_ft = wft; walk_lvl = lvl;
    vaddr = va; nofault_mode = nf;
    chk_entry = 32'hABC0_0001 | ({29'd0, code} << 2) | ({31'd0, md} << 6);
    idx = {k == 2'd1, k == 2'd2, sup};
    ft  = (wft != 3'd0) ? wft : model_ft(k, !sup, code);
    fl  = (wft != 3'd0) ? lvl : 2'd0;
    e = '0;
    if (ft != 3'd0) begin
      m_fsr = {fl, idx, ft, 1'b1, (m_fsr != 10'd0)};
      m_far = va;
      e.rights = nf ? 3'b111 : 3'b000;
      e.trap   = !nf;
      e.tfetch = !nf && (k == 2'd2);
    end else begin
      e.rights = model_rights(!sup, code) & {1'b1, md, 1'b1};
    end
    e.fsr = m_fsr;
    e.far = m_far;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic read_fsr;
    @(negedge clk);
    fsr_rd = 1'b1;
    @(negedge clk);
    fsr_rd = 1'b0;
    m_fsr = '0;
    check("R8 status read clears", {54'd0, fsr}, 64'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected done", 64'd1, 64'd0);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {15'd0, perm_r, perm_w, perm_x, trap, trap_fetch, fsr, far},
              {15'd0, e.rights, e.trap, e.tfetch, e.fsr, e.far});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    check("watchdog expired", 64'd1, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chk_valid = 1'b0; chk_entry = '0; walk_ft = '0; walk_lvl = '0;
    acc_kind = '0; is_super = 1'b0; vaddr = '0; nofault_mode = 1'b0; fsr_rd = 1'b0;
    m_fsr = '0; m_far = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset state", {26'd0, done, trap, trap_fetch, perm_r, perm_w, perm_x, fsr, far}, 64'd0);

    req("R3 super load code3 RWX",        2'd0, 1'b1, 3'd3, 1'b1, 3'd0, 2'd0, 32'h1000_0000, 1'b0);
    req("R4 super store code3 unmodified", 2'd1, 1'b1, 3'd3, 1'b0, 3'd0, 2'd0, 32'h1000_1000, 1'b0);
    req("R3 user load code5 read only",   2'd0, 1'b0, 3'd5, 1'b1, 3'd0, 2'd0, 32'h1000_2000, 1'b0);
    req("R3 super load code5 RW",          2'd0, 1'b1, 3'd5, 1'b1, 3'd0, 2'd0, 32'h1000_3000, 1'b0);
    req("R3 super fetch code6 RX",         2'd2, 1'b1, 3'd6, 1'b1, 3'd0, 2'd0, 32'h1000_4000, 1'b0);
    req("R1 user fetch code4 execute",     2'd2, 1'b0, 3'd4, 1'b0, 3'd0, 2'd0, 32'h1000_5000, 1'b0);
    req("R2 R6 R9 user load code6 priv",   2'd0, 1'b0, 3'd6, 1'b1, 3'd0, 2'd0, 32'h2222_3000, 1'b0);
    req("R7 R9 user fetch code0 overflow", 2'd2, 1'b0, 3'd0, 1'b1, 3'd0, 2'd0, 32'h3333_4000, 1'b0);
    read_fsr();
    req("R5 walk fault lvl2 super store",  2'd1, 1'b1, 3'd3, 1'b1, 3'd1, 2'd2, 32'h4444_5000, 1'b0);
    read_fsr();
    req("R2 user store code4 prot",        2'd1, 1'b0, 3'd4, 1'b1, 3'd0, 2'd0, 32'h5555_6000, 1'b0);
    req("R10 nofault user store code5",    2'd1, 1'b0, 3'd5, 1'b1, 3'd0, 2'd0, 32'h6666_7000, 1'b1);
    req("R10 nofault walk fault",          2'd0, 1'b0, 3'd0, 1'b0, 3'd4, 2'd3, 32'h7777_8000, 1'b1);
    req("R1 kind3 treated as load",        2'd3, 1'b1, 3'd4, 1'b1, 3'd0, 2'd0, 32'h8888_9000, 1'b0);
    req("R4 super store code7 modified",   2'd1, 1'b1, 3'd7, 1'b1, 3'd0, 2'd0, 32'h9999_A000, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 all results delivered", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule